// File: doc/BRIEF.md
# System Clock Source Selector and Rate Divider

This block produces the system clock of a small microcontroller core. It takes two free-running source clocks, an on-chip RC oscillator and an external high-frequency input, and builds one gated system clock from whichever source is active. Switching between the sources is glitch-free. The block also generates a clock-enable pulse that marks each system cycle. The length of a system cycle, counted in source cycles, comes from a 3-bit rate code.

The control logic drives three fields. `ext_en` arms the external input. `src_sel` requests the external source. `rate` holds a low-power bit in bit 2 and a two-bit divide code in bits 1:0. The external source is used only when it is both armed and requested. In every other case the block runs from the internal oscillator. The `ext_active` output shows which source actually drives the system clock. Downstream logic qualifies its registers with `sys_ce`.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the internal oscillator drives `sys_clk`, `ext_active` is 0, and the rate in force is 2 source cycles per system cycle (rate code 3'b001).
- R2: `ext_active` becomes 1, and `sys_clk` follows the external clock, only when `ext_en` and `src_sel` are both 1. When either of them is 0, the block returns to the internal oscillator.
- R3: Setting `src_sel` to 1 while `ext_en` is 0 has no effect: `ext_active` stays 0 and `sys_clk` keeps the internal period.
- R4: With `rate[2]`=0, the divide codes in `rate[1:0]` of 0, 1, 2 and 3 give 1, 2, 4 and 8 source cycles per system cycle.
- R5: With `rate[2]`=1, a system cycle lasts 256 source cycles, whatever the value of `rate[1:0]`.
- R6: The same rate codes give the same counts of source cycles on the external source as on the internal one.
- R7: A new rate code is sampled only at the end of a system cycle. The cycle in progress completes at its old length, and the next cycle uses the new length.
- R8: `sys_ce` is high for exactly one source cycle out of every N, where N is the selected ratio. For N=1 it stays high on every cycle.
- R9: `sys_clk` never has a high or low phase shorter than the shorter half-period of the two sources, and at most one source is gated through at any time.
- R10: During a switch, the old source stays active until its own request has crossed a two-flop synchronizer and reached one of its falling edges. Its status therefore does not drop when the request changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal RC oscillator clock |
| clk_ext | input | 1 | External high-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Arms the external clock input |
| src_sel | input | 1 | 1 requests the external source |
| rate | input | 3 | Bit 2 low-power, bits 1:0 divide code |
| sys_clk | output | 1 | Glitch-free gated system clock |
| sys_ce | output | 1 | One-source-cycle system cycle enable |
| ext_active | output | 1 | 1 while the external source drives sys_clk |

## Verification
`sys_ce` is registered on `sys_clk`, so the bench samples it on falling edges of `sys_clk` and counts falling edges between its high samples. Each count is one source cycle. After a rate change the bench discards two whole system cycles before it compares a gap, because R7 holds the old length until the next boundary. A source switch takes two synchronizer edges and one falling edge in each domain, which is under eight source cycles. The bench therefore waits 40 internal cycles before it reads `ext_active` and times two rising edges of `sys_clk`. Glitch checks run all the time on every edge of `sys_clk`.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   // log2 of the source cycles per system cycle for a rate setting
   function automatic int unsigned div_log2(logic lowpwr, int unsigned code,
                                            int unsigned lp_log2);
      return lowpwr ? lp_log2 : code;
   endfunction

endpackage

// File: rtl/clksel_branch.sv
// One leg of the glitch-free clock switch: request synchronizer on the
// rising edge of the leg's own clock, gate enable updated on its falling edge.
module clksel_branch #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RST_ON      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic en
);

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{RST_ON}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], req};
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en <= RST_ON;
      else        en <= sync_q[SYNC_STAGES-1];
   end

endmodule

// File: rtl/clksel_mux.sv
module clksel_mux #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_int,
   input  logic       clk_ext,
   input  logic       rst_n,
   input  logic       pick_ext,
   output logic       clk_out,
   output logic [1:0] gate_en
);
   import clksel_pkg::*;

   localparam int unsigned NSRC = 2;

   logic [NSRC-1:0] src_clk;
   logic [NSRC-1:0] want;

   assign src_clk        = {clk_ext, clk_int};
   assign want[SRC_INT]  = ~pick_ext;
   assign want[SRC_EXT]  = pick_ext;

   for (genvar gi = 0; gi < NSRC; gi++) begin : g_leg
      logic leg_req;
      // a leg may only claim the output once the other leg has let go
      assign leg_req = want[gi] & ~gate_en[NSRC-1-gi];

      clksel_branch #(
         .SYNC_STAGES (SYNC_STAGES),
         .RST_ON      (gi == int'(SRC_INT))
      ) u_leg (
         .clk   (src_clk[gi]),
         .rst_n (rst_n),
         .req   (leg_req),
         .en    (gate_en[gi])
      );
   end

   assign clk_out = |(src_clk & gate_en);

endmodule

// File: rtl/clksel_div.sv
module clksel_div #(
   parameter int unsigned         CD_W     = 2,
   parameter int unsigned         LP_LOG2  = 8,
   parameter int unsigned         CNT_W    = 8,
   parameter logic [CD_W:0]       RST_RATE = 3'b001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CD_W:0]    rate,
   output logic             ce,
   output logic [CNT_W-1:0] lim_q
);
   import clksel_pkg::*;

   localparam logic [CNT_W-1:0] RST_LIM = CNT_W'((1 << div_log2(RST_RATE[CD_W],
                                   int'(RST_RATE[CD_W-1:0]), LP_LOG2)) - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_next;
   logic [CNT_W:0]   span;

   always_comb begin
      int unsigned sh;
      sh       = div_log2(rate[CD_W], int'(rate[CD_W-1:0]), LP_LOG2);
      span     = (CNT_W+1)'(1) << sh;
      lim_next = CNT_W'(span - 1'b1);
   end

   assign ce = (cnt_q == lim_q);

   // rate is taken only at the boundary, so every system cycle is whole
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= RST_LIM;
      end else if (ce) begin
         cnt_q <= '0;
         lim_q <= lim_next;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CD_W        = 2,
   parameter int unsigned LP_LOG2     = 8,
   parameter logic [2:0]  RST_RATE    = 3'b001
) (
   input  logic            clk_int,
   input  logic            clk_ext,
   input  logic            rst_n,
   input  logic            ext_en,
   input  logic            src_sel,
   input  logic [CD_W:0]   rate,
   output logic            sys_clk,
   output logic            sys_ce,
   output logic            ext_active
);
   import clksel_pkg::*;

   localparam int unsigned CD_MAX_LOG2 = (1 << CD_W) - 1;
   localparam int unsigned CNT_W = (LP_LOG2 > CD_MAX_LOG2) ? LP_LOG2 : CD_MAX_LOG2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sysclk_ctrl: SYNC_STAGES must be at least 2");
   end
   if (CD_W < 1) begin : g_bad_cd
      $error("sysclk_ctrl: CD_W must be at least 1");
   end
   if (LP_LOG2 < 1 || LP_LOG2 > 16) begin : g_bad_lp
      $error("sysclk_ctrl: LP_LOG2 out of range");
   end

   logic             pick_ext;
   logic [1:0]       gate_en;
   logic [CNT_W-1:0] div_lim;

   assign pick_ext = ext_en & src_sel;

   clksel_mux #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_mux (
      .clk_int  (clk_int),
      .clk_ext  (clk_ext),
      .rst_n    (rst_n),
      .pick_ext (pick_ext),
      .clk_out  (sys_clk),
      .gate_en  (gate_en)
   );

   clksel_div #(
      .CD_W     (CD_W),
      .LP_LOG2  (LP_LOG2),
      .CNT_W    (CNT_W),
      .RST_RATE (RST_RATE[CD_W:0])
   ) u_div (
      .clk   (sys_clk),
      .rst_n (rst_n),
      .rate  (rate),
      .ce    (sys_ce),
      .lim_q (div_lim)
   );

   assign ext_active = gate_en[SRC_EXT];

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk_int,
   input logic             sys_clk,
   input logic             rst_n,
   input logic             sys_ce,
   input logic [1:0]       gate_en,
   input logic [CNT_W-1:0] div_lim
);

   logic [CNT_W:0] gap_q;
   logic           seen_q;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (sys_ce) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R9
   gate_excl_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
      $onehot0(gate_en));

   // R8
   ce_gap_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      (sys_ce && seen_q) |-> (gap_q == {1'b0, div_lim}));

   // R7
   rate_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      !sys_ce |=> $stable(div_lim));

   // R4
   ratio_pow2_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
      $countones({1'b0, div_lim} + 1'b1) == 1);

endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_int (clk_int),
   .sys_clk (sys_clk),
   .rst_n   (rst_n),
   .sys_ce  (sys_ce),
   .gate_en (gate_en),
   .div_lim (div_lim)
);

// File: tb/tb_sysclk_ctrl.sv
`timescale 1ns/1ps
module tb_sysclk_ctrl;

   logic       clk_int = 1'b0;
   logic       clk_ext = 1'b0;
   logic       rst_n   = 1'b0;
   logic       ext_en  = 1'b0;
   logic       src_sel = 1'b0;
   logic [2:0] rate    = 3'b001;
   logic       sys_clk;
   logic       sys_ce;
   logic       ext_active;

   int checks = 0;
   int errors = 0;
   int glitches = 0;
   bit edge_seen = 1'b0;
   realtime last_edge = 0.0;

   localparam int INT_PS = 8000;
   localparam int EXT_PS = 6000;

   sysclk_ctrl dut (
      .clk_int    (clk_int),
      .clk_ext    (clk_ext),
      .rst_n      (rst_n),
      .ext_en     (ext_en),
      .src_sel    (src_sel),
      .rate       (rate),
      .sys_clk    (sys_clk),
      .sys_ce     (sys_ce),
      .ext_active (ext_active)
   );

   always #4 clk_int = ~clk_int;
   initial begin
      #1.3;
      forever #3 clk_ext = ~clk_ext;
   end

   // R9: no phase shorter than the 3 ns ext half period
   always @(sys_clk) begin
      if (edge_seen && rst_n && ($realtime - last_edge) < 2.9) glitches++;
      edge_seen = 1'b1;
      last_edge = $realtime;
   end

   function automatic int exp_n(logic [2:0] r);
      return r[2] ? 256 : (1 << r[1:0]);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic next_gap(output int g);
      g = 0;
      do begin
         @(negedge sys_clk);
         g++;
      end while (sys_ce !== 1'b1);
   endtask

   task automatic period_ps(output int p);
      realtime t0;
      @(posedge sys_clk); t0 = $realtime;
      @(posedge sys_clk);
      p = int'(($realtime - t0) * 1000.0);
   endtask

   task automatic set_rate_and_check(logic [2:0] r, string req);
      int g;
      @(negedge sys_clk);
      rate = r;
      next_gap(g);
      next_gap(g);
      next_gap(g);
      chk(g == exp_n(r), req, "source cycles per system cycle", g, exp_n(r));
   endtask

   task automatic settle();
      repeat (40) @(posedge clk_int);
      #1;
   endtask

   task automatic check_source(bit want_ext, string req);
      int p;
      chk(ext_active === want_ext, req, "ext_active", int'(ext_active), int'(want_ext));
      period_ps(p);
      chk(p == (want_ext ? EXT_PS : INT_PS), req, "sys_clk period ps", p,
          want_ext ? EXT_PS : INT_PS);
   endtask

   initial begin
      #1_200_000;
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int g, g2, p;
      void'($urandom(32'h5EED_0A17));
      #50;
      rst_n = 1'b1;
      settle();

      // R1 reset state
      chk(ext_active === 1'b0, "R1", "ext_active after reset", int'(ext_active), 0);
      period_ps(p);
      chk(p == INT_PS, "R1", "internal period after reset", p, INT_PS);
      next_gap(g); next_gap(g);
      chk(g == 2, "R1", "reset ratio", g, 2);

      // R4 all ratios with low-power off
      for (int cd = 0; cd < 4; cd++) set_rate_and_check({1'b0, 2'(cd)}, "R4");
      // R5 low-power ignores divide code
      set_rate_and_check(3'b100, "R5");
      set_rate_and_check(3'b110, "R5");

      // R8 ratio 1: sys_ce high on every source cycle
      set_rate_and_check(3'b000, "R8");
      for (int k = 0; k < 10; k++) begin
         @(negedge sys_clk);
         chk(sys_ce === 1'b1, "R8", "ce at ratio 1", int'(sys_ce), 1);
      end
      // R8 ratio 4: exactly one high sample in four
      set_rate_and_check(3'b010, "R8");
      g2 = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge sys_clk);
         if (sys_ce === 1'b1) g2++;
      end
      chk(g2 == 4, "R8", "ce samples in 16 cycles", g2, 4);

      // R7 mid-cycle rate change keeps the running cycle whole
      set_rate_and_check(3'b011, "R7");
      repeat (3) @(negedge sys_clk);
      rate = 3'b010;
      next_gap(g);
      chk(g + 3 == 8, "R7", "length of interrupted cycle", g + 3, 8);
      next_gap(g);
      chk(g == 4, "R7", "first cycle at new rate", g, 4);

      // R3 request without arming
      src_sel = 1'b1;
      settle();
      check_source(1'b0, "R3");

      // R2 arm and switch
      ext_en = 1'b1;
      settle();
      check_source(1'b1, "R2");

      // R6 same ratios on the external source
      set_rate_and_check(3'b010, "R6");
      set_rate_and_check(3'b101, "R6");
      set_rate_and_check(3'b001, "R6");

      // R10 old source held until its synchronizer and falling edge
      @(negedge clk_ext);
      src_sel = 1'b0;
      #0.5;
      chk(ext_active === 1'b1, "R10", "ext held right after release request",
          int'(ext_active), 1);
      @(posedge clk_ext); #0.5;
      chk(ext_active === 1'b1, "R10", "ext held after one sync edge", int'(ext_active), 1);
      settle();
      check_source(1'b0, "R10");

      // R2 disarming while on external returns to internal
      src_sel = 1'b1;
      settle();
      check_source(1'b1, "R2");
      ext_en = 1'b0;
      settle();
      check_source(1'b0, "R2");

      // random source and rate mixes
      for (int it = 0; it < 24; it++) begin
         logic       e, s;
         logic [2:0] r;
         e = 1'($urandom);
         s = 1'($urandom);
         r = 3'($urandom);
         if (it % 3 != 0) r[2] = 1'b0;
         ext_en  = e;
         src_sel = s;
         settle();
         check_source(e & s, (e & s) ? "R2" : "R3");
         set_rate_and_check(r, r[2] ? "R5" : "R6");
      end

      chk(glitches == 0, "R9", "short sys_clk phases", glitches, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule